// File: doc/BRIEF.md
# Bus-Master DMA Register Window Decoder

This block sits between a host I/O port and two bus-master DMA channels of a disk controller. It decodes a 16-byte I/O window. Each channel owns an 8-byte slice of it. The lower half of a slice holds byte-wide control registers: the command and status registers, which belong to the channel's DMA engine, one timing byte per channel, and a mode byte that both channels share. The upper half of each slice is a 4-byte sub-window for the channel's descriptor pointer. Accesses there are passed straight on to the owning engine.

Byte writes to command or status leave the block as one-cycle strobes, together with the data byte. Byte writes to a timing byte are stored here, and the stored value drives the channel's timing logic. The shared mode byte gathers the per-channel interrupt levels and the per-channel interrupt block bits, and it produces the single interrupt output. In the control half, an access wider than one byte is handled in a fixed way: a read returns all ones, and a write does nothing.

Read data is registered. A small two-state machine marks it valid. In state RD_IDLE, `rvalid_o` is low. A read request in any state moves the machine to RD_VALID for the following cycle. In that cycle `rvalid_o` is high and `rdata_o` holds the captured value. A cycle with no read request returns the machine to RD_IDLE.

Top module: `bmw_window`

## Requirements
- R1: While reset is asserted and right after it is released, `rvalid_o` is 0, `rdata_o` is 0, `timing_o` is 0, and `irq_o` is 0 when both interrupt inputs are low. A byte read of the mode byte then returns 0x00.
- R2: Address bit 3 selects the channel. Bit 2 = 1 selects the descriptor-pointer sub-window. With bit 2 = 0, bits 1:0 select the register: 0 command, 1 mode byte, 2 status, 3 timing byte.
- R3: A byte write (`width_i` = 0) to command or status pulses exactly one bit of `cmd_wr_o` or `sts_wr_o`, the one indexed by address bit 3. The pulse lasts only during the request cycle, and `eng_wdata_o` carries the data byte in that cycle.
- R4: In the cycle after a read request, `rvalid_o` is 1. In a cycle that follows no read request, it is 0. A byte read of command or status returns the owning channel's `eng_cmd_i` / `eng_sts_i` byte, zero-extended in `rdata_o[7:0]`.
- R5: Each channel's timing byte is written in full by a byte write and reads back unchanged. Channel c drives `timing_o[8c+7:8c]`. Writing one channel's timing byte leaves the other's unchanged.
- R6: A byte write to the mode byte through either channel changes only bits 5:4. Both channels read back the same mode byte.
- R7: Mode byte bit 2+c shows `chan_irq_i[c]` as it was sampled at the previous clock edge. Bits 7:6 and 1:0 read as 0.
- R8: `irq_o` = (mode bit 2 AND NOT bit 4) OR (mode bit 3 AND NOT bit 5). It follows a mode write from the clock edge that stores it.
- R9: A read in the control half with `width_i` not 0 returns all ones over the access width: code 1 (2 bytes) gives 0x0000FFFF, and codes 2 and 3 (4 bytes) give 0xFFFFFFFF.
- R10: A write in the control half with `width_i` not 0 produces no command or status strobe. It changes neither the timing bytes nor the mode byte.
- R11: An access of any width with address bit 2 = 1 pulses `ptr_req_o` for the channel selected by bit 3, forwarding `we_i`, `addr_i[1:0]`, `width_i` and `wdata_i`. A read there returns that channel's 32-bit `ptr_rdata_i` word, registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset inside the window |
| width_i | input | 2 | Access width: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| wdata_i | input | 32 | Write data, low byte first |
| rdata_o | output | 32 | Registered read data |
| rvalid_o | output | 1 | Read data valid |
| cmd_wr_o | output | 2 | Per-channel command write strobe |
| sts_wr_o | output | 2 | Per-channel status write strobe |
| eng_wdata_o | output | 8 | Data byte for the command or status strobe |
| eng_cmd_i | input | 16 | Current command byte of each engine (channel c at bits 8c+7:8c) |
| eng_sts_i | input | 16 | Current status byte of each engine |
| ptr_req_o | output | 2 | Per-channel descriptor-pointer access strobe |
| ptr_we_o | output | 1 | Write flag for the pointer access |
| ptr_off_o | output | 2 | Byte offset inside the pointer sub-window |
| ptr_width_o | output | 2 | Width code of the pointer access |
| ptr_wdata_o | output | 32 | Write data for the pointer access |
| ptr_rdata_i | input | 64 | Pointer read word of each channel (channel c at bits 32c+31:32c) |
| chan_irq_i | input | 2 | Interrupt level of each channel |
| irq_o | output | 1 | Combined, unblocked interrupt |
| timing_o | output | 16 | Stored timing byte of each channel |

## Verification
The bench targets the mode byte's partial write. It sets an interrupt level, then writes all zeros and all ones to the mode byte. A decoder that stored the whole byte would lose the interrupt status bits or set the constant bits. The bench also checks the block bits against `irq_o` in both directions, which exposes a swapped or inverted block mask. Wide writes to timing, mode and command addresses must leave every strobe low and every stored byte unchanged, and wide reads must return exact all-ones masks; a decoder that ignored the width would store data or leak register bytes there. Pointer accesses are checked for the right channel strobe and for the full 32-bit read word, and cross-channel writes are checked for independence, which catches a decode that uses the wrong address bit for the channel.

// File: rtl/bmw_pkg.sv
package bmw_pkg;

    localparam int CH_N      = 2;
    localparam int CH_SPAN   = 8;
    localparam int WIN_BYTES = CH_N * CH_SPAN;
    localparam int ADDR_W    = $clog2(WIN_BYTES);
    localparam int CH_IDX_W  = $clog2(CH_N);
    localparam int DATA_W    = 32;
    localparam int BYTE_W    = 8;

    // positions inside the shared mode byte
    localparam int MODE_IRQ_LSB = 2;
    localparam int MODE_BLK_LSB = 4;

    typedef enum logic [1:0] {
        W_BYTE = 2'd0,
        W_HALF = 2'd1,
        W_WORD = 2'd2,
        W_WIDE = 2'd3
    } width_e;

    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_MODE = 2'd1,
        REG_STS  = 2'd2,
        REG_TIM  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_VALID = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic                ctl_hit;
        logic                ptr_hit;
        logic                byte_ok;
        logic [CH_IDX_W-1:0] ch;
        reg_sel_e            sel;
    } dec_t;

    function automatic logic [DATA_W-1:0] ones_for(input width_e w);
        logic [DATA_W-1:0] m;
        unique case (w)
            W_BYTE:  m = {{(DATA_W-8){1'b0}}, 8'hFF};
            W_HALF:  m = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            W_WORD:  m = {DATA_W{1'b1}};
            W_WIDE:  m = {DATA_W{1'b1}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/bmw_addr_dec.sv
module bmw_addr_dec
    import bmw_pkg::*;
(
    input  logic                 req_i,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [1:0]           width_i,
    output dec_t                 dec_o,
    output logic [CH_N-1:0]      cmd_wr_o,
    output logic [CH_N-1:0]      sts_wr_o,
    output logic [CH_N-1:0]      tim_wr_o,
    output logic                 mode_wr_o,
    output logic [CH_N-1:0]      ptr_req_o
);

    localparam int PTR_BIT = 2;

    dec_t d;
    logic ctl_wr;

    always_comb begin
        d.ptr_hit = addr_i[PTR_BIT];
        d.ctl_hit = !addr_i[PTR_BIT];
        d.byte_ok = (width_e'(width_i) == W_BYTE);
        d.ch      = addr_i[ADDR_W-1 -: CH_IDX_W];
        d.sel     = reg_sel_e'(addr_i[1:0]);
    end

    assign dec_o     = d;
    // only byte-wide writes in the control half have an effect
    assign ctl_wr    = req_i && we_i && d.ctl_hit && d.byte_ok;
    assign mode_wr_o = ctl_wr && (d.sel == REG_MODE);

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        logic own;
        assign own          = (d.ch == CH_IDX_W'(c));
        assign cmd_wr_o[c]  = ctl_wr && own && (d.sel == REG_CMD);
        assign sts_wr_o[c]  = ctl_wr && own && (d.sel == REG_STS);
        assign tim_wr_o[c]  = ctl_wr && own && (d.sel == REG_TIM);
        assign ptr_req_o[c] = req_i && d.ptr_hit && own;
    end

endmodule

// File: rtl/bmw_mode_reg.sv
module bmw_mode_reg
    import bmw_pkg::*;
#(
    parameter logic [7:0] MODE_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_N-1:0]   chan_irq_i,
    input  logic              mode_wr_i,
    input  logic [7:0]        wbyte_i,
    output logic [7:0]        mode_o,
    output logic              irq_o
);

    logic [CH_N-1:0] irq_q;
    logic [CH_N-1:0] blk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
            blk_q <= MODE_RST[MODE_BLK_LSB +: CH_N];
        end else begin
            irq_q <= chan_irq_i;
            if (mode_wr_i) begin
                blk_q <= wbyte_i[MODE_BLK_LSB +: CH_N];
            end
        end
    end

    always_comb begin
        mode_o = MODE_RST;
        mode_o[MODE_IRQ_LSB +: CH_N] = irq_q;
        mode_o[MODE_BLK_LSB +: CH_N] = blk_q;
    end

    assign irq_o = |(irq_q & ~blk_q);

endmodule

// File: rtl/bmw_timing_regs.sv
module bmw_timing_regs
    import bmw_pkg::*;
#(
    parameter logic [7:0] TIM_RST = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CH_N-1:0]       tim_wr_i,
    input  logic [7:0]            wbyte_i,
    output logic [CH_N*8-1:0]     timing_o
);

    for (genvar c = 0; c < CH_N; c++) begin : g_tim
        logic [7:0] tim_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tim_q <= TIM_RST;
            end else if (tim_wr_i[c]) begin
                tim_q <= wbyte_i;
            end
        end
        assign timing_o[c*8 +: 8] = tim_q;
    end

endmodule

// File: rtl/bmw_rd_path.sv
module bmw_rd_path
    import bmw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_req_i,
    input  dec_t                   dec_i,
    input  logic [1:0]             width_i,
    input  logic [CH_N*8-1:0]      eng_cmd_i,
    input  logic [CH_N*8-1:0]      eng_sts_i,
    input  logic [7:0]             mode_i,
    input  logic [CH_N*8-1:0]      timing_i,
    input  logic [CH_N*32-1:0]     ptr_rdata_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic                   rvalid_o
);

    rd_state_e state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_val;
    logic [7:0]        byte_val;

    logic [7:0]  cmd_b [CH_N];
    logic [7:0]  sts_b [CH_N];
    logic [7:0]  tim_b [CH_N];
    logic [31:0] ptr_w [CH_N];

    for (genvar c = 0; c < CH_N; c++) begin : g_unpack
        assign cmd_b[c] = eng_cmd_i[c*8 +: 8];
        assign sts_b[c] = eng_sts_i[c*8 +: 8];
        assign tim_b[c] = timing_i[c*8 +: 8];
        assign ptr_w[c] = ptr_rdata_i[c*32 +: 32];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: any read request leads to RD_VALID, otherwise RD_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  state_d = rd_req_i ? RD_VALID : RD_IDLE;
            RD_VALID: state_d = rd_req_i ? RD_VALID : RD_IDLE;
        endcase
    end

    always_comb begin
        unique case (dec_i.sel)
            REG_CMD:  byte_val = cmd_b[dec_i.ch];
            REG_MODE: byte_val = mode_i;
            REG_STS:  byte_val = sts_b[dec_i.ch];
            REG_TIM:  byte_val = tim_b[dec_i.ch];
        endcase
    end

    always_comb begin
        if (dec_i.ptr_hit) begin
            rd_val = ptr_w[dec_i.ch];
        end else if (!dec_i.byte_ok) begin
            rd_val = ones_for(width_e'(width_i));
        end else begin
            rd_val = {{(DATA_W-8){1'b0}}, byte_val};
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_req_i) begin
            rdata_q <= rd_val;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = (state_q == RD_VALID);

endmodule

// File: rtl/bmw_window.sv
module bmw_window
    import bmw_pkg::*;
#(
    parameter logic [7:0] MODE_RST = 8'h00,
    parameter logic [7:0] TIM_RST  = 8'h00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_i,
    input  logic                  we_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [1:0]            width_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  rvalid_o,
    output logic [CH_N-1:0]       cmd_wr_o,
    output logic [CH_N-1:0]       sts_wr_o,
    output logic [7:0]            eng_wdata_o,
    input  logic [CH_N*8-1:0]     eng_cmd_i,
    input  logic [CH_N*8-1:0]     eng_sts_i,
    output logic [CH_N-1:0]       ptr_req_o,
    output logic                  ptr_we_o,
    output logic [1:0]            ptr_off_o,
    output logic [1:0]            ptr_width_o,
    output logic [DATA_W-1:0]     ptr_wdata_o,
    input  logic [CH_N*32-1:0]    ptr_rdata_i,
    input  logic [CH_N-1:0]       chan_irq_i,
    output logic                  irq_o,
    output logic [CH_N*8-1:0]     timing_o
);

    dec_t            dec;
    logic [CH_N-1:0] tim_wr;
    logic            mode_wr;
    logic [7:0]      mode_byte;

    bmw_addr_dec u_dec (
        .req_i     (req_i),
        .we_i      (we_i),
        .addr_i    (addr_i),
        .width_i   (width_i),
        .dec_o     (dec),
        .cmd_wr_o  (cmd_wr_o),
        .sts_wr_o  (sts_wr_o),
        .tim_wr_o  (tim_wr),
        .mode_wr_o (mode_wr),
        .ptr_req_o (ptr_req_o)
    );

    bmw_mode_reg #(.MODE_RST(MODE_RST)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_irq_i (chan_irq_i),
        .mode_wr_i  (mode_wr),
        .wbyte_i    (wdata_i[7:0]),
        .mode_o     (mode_byte),
        .irq_o      (irq_o)
    );

    bmw_timing_regs #(.TIM_RST(TIM_RST)) u_tim (
        .clk      (clk),
        .rst_n    (rst_n),
        .tim_wr_i (tim_wr),
        .wbyte_i  (wdata_i[7:0]),
        .timing_o (timing_o)
    );

    bmw_rd_path u_rd (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req_i    (req_i && !we_i),
        .dec_i       (dec),
        .width_i     (width_i),
        .eng_cmd_i   (eng_cmd_i),
        .eng_sts_i   (eng_sts_i),
        .mode_i      (mode_byte),
        .timing_i    (timing_o),
        .ptr_rdata_i (ptr_rdata_i),
        .rdata_o     (rdata_o),
        .rvalid_o    (rvalid_o)
    );

    assign eng_wdata_o = wdata_i[7:0];
    assign ptr_we_o    = we_i;
    assign ptr_off_o   = addr_i[1:0];
    assign ptr_width_o = width_i;
    assign ptr_wdata_o = wdata_i;

endmodule

// File: rtl/bmw_window_chk.sv
module bmw_window_chk
    import bmw_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_i,
    input logic                  we_i,
    input logic [ADDR_W-1:0]     addr_i,
    input logic [1:0]            width_i,
    input logic [DATA_W-1:0]     rdata_o,
    input logic                  rvalid_o,
    input logic [CH_N-1:0]       cmd_wr_o,
    input logic [CH_N-1:0]       sts_wr_o,
    input logic [CH_N-1:0]       ptr_req_o,
    input logic [CH_N-1:0]       chan_irq_i,
    input logic                  irq_o,
    input logic [CH_N*8-1:0]     timing_o
);

    // R3
    cmd_strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_wr_o) && $onehot0(sts_wr_o));

    // R3
    cmd_strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_wr_o) |-> (req_i && we_i && width_i == 2'd0 && !addr_i[2] && addr_i[1:0] == 2'd0));

    // R4
    rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i) |=> rvalid_o);

    // R4
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_o && $past(rst_n)) |-> $past(req_i && !we_i));

    // R5
    timing_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(timing_o) && $past(rst_n)) |->
            $past(req_i && we_i && width_i == 2'd0 && !addr_i[2] && addr_i[1:0] == 2'd3));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chan_irq_i) == '0) |-> !irq_o);

    // R9
    wide_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !we_i && !addr_i[2] && width_i == 2'd1) |=> (rdata_o == 32'h0000_FFFF));

    // R10
    wide_write_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && we_i && !addr_i[2] && width_i != 2'd0) |-> (cmd_wr_o == '0 && sts_wr_o == '0));

    // R11
    ptr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_req_o != '0) |-> (req_i && addr_i[2] && $onehot(ptr_req_o) && ptr_req_o[addr_i[3]]));

endmodule

bind bmw_window bmw_window_chk chk_i (.*);

// File: tb/bmw_window_tb.sv
module bmw_window_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        we_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic [1:0]  width_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        rvalid_o;
    logic [1:0]  cmd_wr_o, sts_wr_o, ptr_req_o;
    logic [7:0]  eng_wdata_o;
    logic [15:0] eng_cmd_i = 16'h3C81;
    logic [15:0] eng_sts_i = 16'h6E27;
    logic        ptr_we_o;
    logic [1:0]  ptr_off_o, ptr_width_o;
    logic [31:0] ptr_wdata_o;
    logic [63:0] ptr_rdata_i = 64'h0BAD_F00D_DEAD_BEEF;
    logic [1:0]  chan_irq_i = '0;
    logic        irq_o;
    logic [15:0] timing_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bmw_window dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // drive an access at a falling edge; effects of strobes are visible at once
    task automatic start_acc(input logic w, input logic [3:0] a, input logic [1:0] wd,
                             input logic [31:0] d);
        req_i = 1'b1; we_i = w; addr_i = a; width_i = wd; wdata_i = d;
        #2;
    endtask

    // let the request be sampled, then drop it at the next falling edge
    task automatic end_acc();
        @(posedge clk);
        @(negedge clk);
        req_i = 1'b0; we_i = 1'b0;
        #2;
    endtask

    task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
        start_acc(1'b1, a, 2'd0, {24'h0, d});
        end_acc();
    endtask

    task automatic rd(input logic [3:0] a, input logic [1:0] wd, output logic [31:0] v);
        start_acc(1'b0, a, wd, 32'h0);
        end_acc();
        v = rdata_o;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rvalid", {31'h0, rvalid_o}, 32'h0);
        chk("R1 rdata", rdata_o, 32'h0);
        chk("R1 timing", {16'h0, timing_o}, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);
        rd(4'd1, 2'd0, v);
        chk("R1 mode reset", v, 32'h0);
    endtask

    task automatic t_cmd_sts();
        logic [31:0] v;
        start_acc(1'b1, 4'd0, 2'd0, 32'hFFFF_FFA5);
        chk("R3 cmd strobe ch0", {30'h0, cmd_wr_o}, 32'h1);
        chk("R3 no sts strobe", {30'h0, sts_wr_o}, 32'h0);
        chk("R3 eng data", {24'h0, eng_wdata_o}, 32'hA5);
        end_acc();
        chk("R3 strobe one cycle", {30'h0, cmd_wr_o}, 32'h0);
        start_acc(1'b1, 4'd10, 2'd0, 32'h0000_005B);
        chk("R3 R2 sts strobe ch1", {30'h0, sts_wr_o}, 32'h2);
        chk("R3 no cmd strobe", {30'h0, cmd_wr_o}, 32'h0);
        end_acc();
        rd(4'd8, 2'd0, v);
        chk("R4 cmd read ch1", v, 32'h3C);
        chk("R4 rvalid after read", {31'h0, rvalid_o}, 32'h1);
        rd(4'd2, 2'd0, v);
        chk("R4 R2 sts read ch0", v, 32'h27);
        @(negedge clk); #2;
        chk("R4 rvalid drops", {31'h0, rvalid_o}, 32'h0);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        wr_byte(4'd3, 8'h5A);
        chk("R5 timing ch0 only", {16'h0, timing_o}, 32'h005A);
        wr_byte(4'd11, 8'hC3);
        chk("R5 timing both", {16'h0, timing_o}, 32'hC35A);
        rd(4'd3, 2'd0, v);
        chk("R5 read tim ch0", v, 32'h5A);
        rd(4'd11, 2'd0, v);
        chk("R5 read tim ch1", v, 32'hC3);
    endtask

    task automatic t_mode();
        logic [31:0] v;
        wr_byte(4'd9, 8'h10);
        rd(4'd1, 2'd0, v);
        chk("R6 shared via ch0", v, 32'h10);
        chk("R8 blocked no irq", {31'h0, irq_o}, 32'h0);
        wr_byte(4'd1, 8'hFF);
        rd(4'd9, 2'd0, v);
        chk("R6 R7 only bits 5:4", v, 32'h30);
        wr_byte(4'd1, 8'h00);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        @(negedge clk); chan_irq_i = 2'b01;
        @(negedge clk); #2;
        chk("R8 ch0 irq unblocked", {31'h0, irq_o}, 32'h1);
        rd(4'd1, 2'd0, v);
        chk("R7 irq bit2", v, 32'h04);
        wr_byte(4'd1, 8'hFF);
        chk("R8 ch0 blocked", {31'h0, irq_o}, 32'h0);
        rd(4'd9, 2'd0, v);
        chk("R6 R7 irq bit kept", v, 32'h34);
        wr_byte(4'd9, 8'h20);
        chk("R8 ch1 block does not hide ch0", {31'h0, irq_o}, 32'h1);
        chan_irq_i = 2'b10;
        @(negedge clk); #2;
        chk("R8 ch1 blocked", {31'h0, irq_o}, 32'h0);
        wr_byte(4'd1, 8'h00);
        chk("R8 ch1 unblocked", {31'h0, irq_o}, 32'h1);
        rd(4'd1, 2'd0, v);
        chk("R7 irq bit3", v, 32'h08);
        chan_irq_i = 2'b00;
        @(negedge clk); #2;
        chk("R7 R8 irq cleared", {31'h0, irq_o}, 32'h0);
    endtask

    task automatic t_wide();
        logic [31:0] v;
        rd(4'd0, 2'd1, v);
        chk("R9 half read", v, 32'h0000_FFFF);
        rd(4'd11, 2'd2, v);
        chk("R9 word read", v, 32'hFFFF_FFFF);
        rd(4'd1, 2'd3, v);
        chk("R9 wide code 3", v, 32'hFFFF_FFFF);
        start_acc(1'b1, 4'd0, 2'd1, 32'h0000_FFFF);
        chk("R10 no cmd strobe", {30'h0, cmd_wr_o}, 32'h0);
        end_acc();
        start_acc(1'b1, 4'd10, 2'd2, 32'hFFFF_FFFF);
        chk("R10 no sts strobe", {30'h0, sts_wr_o}, 32'h0);
        end_acc();
        start_acc(1'b1, 4'd3, 2'd1, 32'h0000_1111);
        end_acc();
        chk("R10 timing kept", {16'h0, timing_o}, 32'hC35A);
        start_acc(1'b1, 4'd1, 2'd2, 32'hFFFF_FFFF);
        end_acc();
        rd(4'd1, 2'd0, v);
        chk("R10 mode kept", v, 32'h00);
    endtask

    task automatic t_ptr();
        logic [31:0] v;
        start_acc(1'b1, 4'd12, 2'd2, 32'h1234_5678);
        chk("R11 ptr strobe ch1", {30'h0, ptr_req_o}, 32'h2);
        chk("R11 ptr fields", {ptr_wdata_o[27:0], ptr_we_o, ptr_width_o, ptr_off_o[0]},
            {28'h234_5678, 1'b1, 2'd2, 1'b0});
        chk("R11 no cmd strobe", {28'h0, cmd_wr_o, sts_wr_o}, 32'h0);
        end_acc();
        chk("R11 ptr strobe ends", {30'h0, ptr_req_o}, 32'h0);
        start_acc(1'b0, 4'd5, 2'd0, 32'h0);
        chk("R11 ptr read ch0", {29'h0, ptr_req_o, ptr_we_o}, {29'h0, 2'b01, 1'b0});
        chk("R11 ptr off", {30'h0, ptr_off_o}, 32'h1);
        end_acc();
        chk("R11 ptr rdata ch0", rdata_o, 32'hDEAD_BEEF);
        rd(4'd14, 2'd1, v);
        chk("R11 ptr rdata ch1", v, 32'h0BAD_F00D);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        t_reset();
        t_cmd_sts();
        t_timing();
        t_mode();
        t_irq();
        t_wide();
        t_ptr();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule